// File: doc/BRIEF.md
# Integer Execute Stage with Word Compatibility

This block is the registered execute stage of a 64-bit integer datapath. Older 32-bit instructions must keep giving the same low-word results they gave on a 32-bit machine, and the stage extends those results correctly into the upper half. Each cycle it accepts an opcode, two 64-bit operands, a 16-bit immediate and a valid flag. One clock later it returns a 64-bit result, a result-valid flag and an overflow exception flag.

Two add-immediate forms are supported. The word form checks for signed overflow at bit 31 and sign-extends its 32-bit sum. The double-word form checks for signed overflow at bit 63. Both forms sign-extend the immediate. The logical AND-immediate zero-extends it. The stage also formats data returned from memory, on the second operand, for signed-word, unsigned-word and double-word loads. When overflow is raised, the valid flag is withheld so that no register is written.

Top module: `int_exec64`

## Requirements
- R1: All outputs are registered. An input with `in_valid` high produces its outputs in the next cycle. A cycle with `in_valid` low leaves `out_valid` and `out_ovf` low in the next cycle. A synchronous reset (`rst_n` low) clears `out_valid`, `out_ovf` and `out_result`.
- R2: Opcode 0 (word add-immediate) sign-extends the immediate and adds it to `op_a[31:0]`. The result is the 32-bit sum, sign-extended from bit 31 into bits 63:32.
- R3: For opcode 0, `out_ovf` is 1 when the signed 32-bit sum overflows (the carries out of bits 30 and 31 differ). In that case `out_valid` is 0.
- R4: Opcode 1 (double-word add-immediate) sign-extends the immediate and returns the 64-bit sum with `op_a`.
- R5: For opcode 1, `out_ovf` is 1 when the signed 64-bit sum overflows (the carries out of bits 62 and 63 differ). In that case `out_valid` is 0. A carry past bit 31 alone is not overflow for this opcode.
- R6: Opcode 2 (AND-immediate) returns `op_a` ANDed with the immediate zero-extended to 64 bits.
- R7: Opcode 3 (signed word load) returns `op_b[31:0]` sign-extended to 64 bits.
- R8: Opcode 4 (unsigned word load) returns `op_b[31:0]` zero-extended to 64 bits.
- R9: Opcode 5 (double-word load) returns `op_b` unchanged.
- R10: Opcodes 6 and 7 produce neither `out_valid` nor `out_ovf`.
- R11: The word operations ignore `op_a[63:32]`, so their low 32 bits match a pure 32-bit machine. Loads ignore `op_a`.
- R12: Only opcodes 0 and 1 can raise `out_ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode (0..5 defined) |
| op_a | input | 64 | First source operand |
| op_b | input | 64 | Second operand; data returned from memory for loads |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result may be written back |
| out_result | output | 64 | Result |
| out_ovf | output | 1 | Overflow exception |

## Verification
The assertions use `$past` of the inputs, so they assume the inputs are steady and known at every sampled edge once reset is released. The bench meets this by driving every input on the falling edge. It also holds reset low for several cycles, so the look-back never reaches before reset. Stimulus sits on each overflow boundary, on both sides. It also places junk in the operand halves that each operation must ignore.

// File: rtl/int_exec_pkg.sv
// Package: opcode encoding and widths shared by the execute stage.
// Assumes: opcodes outside the enumerated set are treated as undefined.
package int_exec_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_W  = 3'd0,
        OP_ADD_D  = 3'd1,
        OP_AND_I  = 3'd2,
        OP_LOAD_W = 3'd3,
        OP_LOAD_WU = 3'd4,
        OP_LOAD_D = 3'd5
    } exec_op_e;

    typedef enum logic [1:0] {
        LF_SWORD,
        LF_UWORD,
        LF_DWORD
    } load_fmt_e;
endpackage

// File: rtl/imm_extend.sv
// Module: produces sign- and zero-extended copies of a short immediate.
// Assumes: OUT_W > IMM_W.
module imm_extend #(
    parameter int IMM_W = 16,
    parameter int OUT_W = 64
) (
    input  logic [IMM_W-1:0] imm,
    output logic [OUT_W-1:0] imm_sx,
    output logic [OUT_W-1:0] imm_zx
);
    localparam int PAD_W = OUT_W - IMM_W;

    // Replicate the top bit, or pad with zeros.
    always_comb begin
        imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
        imm_zx = {{PAD_W{1'b0}}, imm};
    end
endmodule

// File: rtl/add_ovf.sv
// Module: W-bit adder flagging signed overflow as carry into MSB != carry out.
// Assumes: W >= 2; operands are two's complement.
module add_ovf #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W:0]   full_sum;
    logic [W-1:0] low_sum;

    // Full sum gives carry out of MSB; partial sum gives carry into MSB.
    always_comb begin
        full_sum = {1'b0, a} + {1'b0, b};
        low_sum  = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]};
        sum      = full_sum[W-1:0];
        ovf      = full_sum[W] ^ low_sum[W-1];
    end
endmodule

// File: rtl/load_format.sv
// Module: formats memory return data for word-signed, word-unsigned and
// double-word loads.
// Assumes: XLEN > WLEN; the low WLEN bits hold the fetched word.
module load_format
    import int_exec_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0] data,
    input  load_fmt_e       fmt,
    output logic [XLEN-1:0] formatted
);
    localparam int HI_W = XLEN - WLEN;

    logic [WLEN-1:0] word;

    // Pick the extension for the selected load width.
    always_comb begin
        word = data[WLEN-1:0];
        unique case (fmt)
            LF_SWORD: formatted = {{HI_W{word[WLEN-1]}}, word};
            LF_UWORD: formatted = {{HI_W{1'b0}}, word};
            default:  formatted = data;
        endcase
    end
endmodule

// File: rtl/int_exec64.sv
// Module: registered integer execute stage. Word operations keep 32-bit
// results bit-exact and extend them to 64 bits; double-word operations
// use the full width. Overflow suppresses the result-valid flag.
// Assumes: the inputs are steady around the rising clock edge.
module int_exec64
    import int_exec_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic [IMM_W-1:0] imm,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_ovf
);
    localparam int HI_W = XLEN - WLEN;

    logic [XLEN-1:0] imm_sx, imm_zx;
    logic [WLEN-1:0] sum_w;
    logic [XLEN-1:0] sum_d;
    logic            ovf_w, ovf_d;
    logic [XLEN-1:0] load_res;
    load_fmt_e       lfmt;
    logic [XLEN-1:0] nxt_res;
    logic            nxt_ovf, nxt_def;

    imm_extend #(.IMM_W(IMM_W), .OUT_W(XLEN)) u_imm (
        .imm(imm), .imm_sx(imm_sx), .imm_zx(imm_zx)
    );

    add_ovf #(.W(WLEN)) u_add_w (
        .a(op_a[WLEN-1:0]), .b(imm_sx[WLEN-1:0]), .sum(sum_w), .ovf(ovf_w)
    );

    add_ovf #(.W(XLEN)) u_add_d (
        .a(op_a), .b(imm_sx), .sum(sum_d), .ovf(ovf_d)
    );

    load_format #(.XLEN(XLEN), .WLEN(WLEN)) u_load (
        .data(op_b), .fmt(lfmt), .formatted(load_res)
    );

    // Map a load opcode onto a format selector.
    always_comb begin
        unique case (in_op)
            OP_LOAD_W:  lfmt = LF_SWORD;
            OP_LOAD_WU: lfmt = LF_UWORD;
            default:    lfmt = LF_DWORD;
        endcase
    end

    // Select the next result, overflow and defined-opcode flags.
    always_comb begin
        nxt_res = load_res;
        nxt_ovf = 1'b0;
        nxt_def = 1'b1;
        case (in_op)
            OP_ADD_W: begin
                nxt_res = {{HI_W{sum_w[WLEN-1]}}, sum_w};
                nxt_ovf = ovf_w;
            end
            OP_ADD_D: begin
                nxt_res = sum_d;
                nxt_ovf = ovf_d;
            end
            OP_AND_I:   nxt_res = op_a & imm_zx;
            OP_LOAD_W,
            OP_LOAD_WU,
            OP_LOAD_D:  nxt_res = load_res;
            default:    nxt_def = 1'b0;
        endcase
    end

    // Output register: capture on a valid defined operation, else idle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_ovf    <= 1'b0;
            out_result <= '0;
        end else if (in_valid && nxt_def) begin
            out_valid  <= ~nxt_ovf;
            out_ovf    <= nxt_ovf;
            out_result <= nxt_res;
        end else begin
            out_valid  <= 1'b0;
            out_ovf    <= 1'b0;
        end
    end

    // Idle input cycle gives quiet outputs next cycle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_ovf));

    // An overflow never comes with a writeback.
    p_no_valid_on_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> !out_valid);

    // Word add result is a sign-extended 32-bit value.
    p_word_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ADD_W) |=>
            (out_result[XLEN-1:WLEN] == {HI_W{out_result[WLEN-1]}}));

    // Word add overflow matches the sign rule on the low words.
    p_word_ovf_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ADD_W) |=>
            (out_ovf == (($past(op_a[WLEN-1]) == $past(imm[IMM_W-1])) &&
                         (out_result[WLEN-1] != $past(op_a[WLEN-1])))));

    // Double-word add overflow matches the sign rule on full operands.
    p_dword_ovf_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ADD_D) |=>
            (out_ovf == (($past(op_a[XLEN-1]) == $past(imm[IMM_W-1])) &&
                         (out_result[XLEN-1] != $past(op_a[XLEN-1])))));

    // Loads are always written back.
    p_load_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_LOAD_W || in_op == OP_LOAD_WU ||
                      in_op == OP_LOAD_D)) |=> (out_valid && !out_ovf));

    // Undefined opcodes stay silent.
    p_undef_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > OP_LOAD_D) |=> (!out_valid && !out_ovf));

    // Overflow only follows an add opcode.
    p_ovf_only_add_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> ($past(in_op) == OP_ADD_W || $past(in_op) == OP_ADD_D));
endmodule

// File: tb/test_int_exec64.sv
module test_int_exec64;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [63:0] op_a, op_b;
    logic [15:0] imm;
    logic        out_valid, out_ovf;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    int_exec64 i_int_exec64 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .op_a(op_a), .op_b(op_b), .imm(imm),
        .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // Bench model, written from the requirements with signed arithmetic.
    task automatic model(input logic [2:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] im,
                         output logic [63:0] res, output logic v,
                         output logic ov);
        logic signed [32:0] s33;
        logic signed [64:0] s65;
        res = 64'h0; v = 1'b1; ov = 1'b0;
        case (op)
            3'd0: begin
                s33 = $signed({a[31], a[31:0]}) + $signed({{17{im[15]}}, im});
                ov  = (s33 > 33'sd2147483647) || (s33 < -33'sd2147483648);
                res = {{32{s33[31]}}, s33[31:0]};
            end
            3'd1: begin
                s65 = $signed({a[63], a}) + $signed({{49{im[15]}}, im});
                ov  = s65[64] != s65[63];
                res = s65[63:0];
            end
            3'd2: res = a & {48'h0, im};
            3'd3: res = {{32{b[31]}}, b[31:0]};
            3'd4: res = {32'h0, b[31:0]};
            3'd5: res = b;
            default: v = 1'b0;
        endcase
        if (ov) v = 1'b0;
    endtask

    // Drive one operation on a falling edge and check it one cycle later.
    task automatic run(input string tag, input logic [2:0] op,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [15:0] im);
        logic [63:0] er;
        logic ev, eo;
        model(op, a, b, im, er, ev, eo);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; op_a = a; op_b = b; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "valid", {63'h0, out_valid}, {63'h0, ev});
        check(tag, "ovf", {63'h0, out_ovf}, {63'h0, eo});
        if (ev) check(tag, "result", out_result, er);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_op = 3'd0;
        op_a = '0; op_b = '0; imm = '0;
        repeat (4) @(negedge clk);
        check("R1", "reset valid", {63'h0, out_valid}, 64'h0);
        check("R1", "reset ovf", {63'h0, out_ovf}, 64'h0);
        check("R1", "reset result", out_result, 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_word_add;
        run("R2", 3'd0, 64'h0000_0000_7FFF_FFF0, 64'h0, 16'hFFFF);
        run("R2", 3'd0, 64'h0000_0000_0000_0005, 64'h0, 16'hFFF0);
        run("R2", 3'd0, 64'h0000_0000_7FFF_FFF0, 64'h0, 16'h000F);
    endtask

    task automatic t_word_ovf;
        run("R3", 3'd0, 64'h0000_0000_7FFF_FFF0, 64'h0, 16'h0010);
        run("R3", 3'd0, 64'h0000_0000_8000_0000, 64'h0, 16'hFFFF);
        run("R3", 3'd0, 64'h0000_0000_FFFF_FFFF, 64'h0, 16'h0001);
    endtask

    task automatic t_dword_add;
        run("R4", 3'd1, 64'h1234_5678_0000_0010, 64'h0, 16'hFFEF);
        run("R4", 3'd1, 64'h0000_0000_7FFF_FFFF, 64'h0, 16'h0001);
        run("R5", 3'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'h0001);
        run("R5", 3'd1, 64'h8000_0000_0000_0000, 64'h0, 16'h8000);
        run("R5", 3'd1, 64'h7FFF_FFFF_FFFF_FFFE, 64'h0, 16'h0001);
    endtask

    task automatic t_logic;
        run("R6", 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h8421);
        run("R6", 3'd2, 64'hA5A5_A5A5_A5A5_0F0F, 64'h0, 16'hF0FF);
    endtask

    task automatic t_loads;
        run("R7", 3'd3, 64'hDEAD, 64'h1234_5678_89AB_CDEF, 16'h0);
        run("R7", 3'd3, 64'h0, 64'hFFFF_0000_7654_3210, 16'h0);
        run("R8", 3'd4, 64'hBEEF, 64'h1234_5678_89AB_CDEF, 16'h0);
        run("R9", 3'd5, 64'hCAFE, 64'h1234_5678_89AB_CDEF, 16'h0);
    endtask

    task automatic t_undef;
        run("R10", 3'd6, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0001);
        run("R10", 3'd7, 64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0001);
    endtask

    task automatic t_compat;
        run("R11", 3'd0, 64'hDEAD_BEEF_0000_0005, 64'h0, 16'hFFF0);
        run("R11", 3'd0, 64'h8000_0000_7FFF_FFFF, 64'h0, 16'h0000);
        run("R11", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0001, 16'hFFFF);
    endtask

    task automatic t_ovf_source;
        run("R12", 3'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'hFFFF);
        run("R12", 3'd5, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 16'h7FFF);
    endtask

    task automatic t_idle;
        run("R1", 3'd5, 64'h0, 64'h5555_AAAA_5555_AAAA, 16'h0);
        @(negedge clk);
        check("R1", "idle valid", {63'h0, out_valid}, 64'h0);
        check("R1", "idle ovf", {63'h0, out_ovf}, 64'h0);
    endtask

    initial begin
        t_reset();
        t_word_add();
        t_word_ovf();
        t_dword_add();
        t_logic();
        t_loads();
        t_undef();
        t_compat();
        t_ovf_source();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule